// File: doc/BRIEF.md
# Fractional sample-period strobe generator

The block turns a fast reference clock into a one-cycle sample strobe whose long-run period is a rational number of reference cycles. A single 32-bit configuration word carries a numerator N and a field M that holds the denominator minus one. The average spacing of the strobes is therefore N/(M+1) reference cycles, and the denominator can be anything from 1 to 256.

Internally, a phase accumulator gains (M+1) on every enabled cycle. Whenever it would reach N, N is taken off and a strobe is issued. Individual gaps between strobes are therefore the floor or the ceiling of N/(M+1), and no error builds up over time. Software picks N and M, for example by a best rational approximation within the field widths. Dropping the enable or presenting a different configuration word restarts the phase from zero.

Top module: `frac_strobe_gen`

## Requirements
- R1: During and after reset, with the enable low, the strobe is low and the accumulator is zero.
- R2: The configuration word carries N in bits 31:8 (24 bits) and M in bits 7:0 (8 bits). The denominator is D = M+1.
- R3: With N > D and the configuration stable since the phase restart, the strobe is high after enabled edge t (t = 1, 2, ...) exactly when floor(t·D/N) > floor((t-1)·D/N).
- R4: Starting from a restart, any window of k·N enabled cycles holds exactly k·D strobes.
- R5: With N equal to 0, no strobe is ever issued.
- R6: With N nonzero and N <= D, the strobe is high after every enabled cycle.
- R7: An edge with the enable low clears the phase and gives no strobe. The next enabled edge is counted as t = 1.
- R8: An edge at which the configuration word differs from the one seen at the previous edge clears the phase and gives no strobe. Counting restarts at t = 1 on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low clears the phase |
| cfg_i | input | 32 | Configuration word: N in 31:8, M in 7:0 |
| strobe_o | output | 1 | Registered sample strobe |

## Verification
The strobe is registered. The result of a given rising edge is therefore visible one clock after the inputs that produced it, and a new configuration word costs one edge: it is latched while the phase is cleared, and counting begins on the edge after that. The bench changes inputs on the falling edge and reads the strobe on the next falling edge, so each sample belongs to exactly one rising edge. That edge's index t is known in advance. The expected value comes from the floor formula of R3 for each edge index, and the totals for R4 come from k·D.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int FSG_N_W = 24;
    localparam int FSG_M_W = 8;
endpackage

// File: rtl/fsg_field_split.sv
module fsg_field_split #(
    parameter int N_W = 24,
    parameter int M_W = 8,
    localparam int CFG_W = N_W + M_W
) (
    input  logic [CFG_W-1:0] cfg,
    output logic [N_W-1:0]   num,
    output logic [M_W:0]     den
);
    always_comb begin
        num = cfg[CFG_W-1:M_W];
        den = {1'b0, cfg[M_W-1:0]} + {{M_W{1'b0}}, 1'b1};
    end
endmodule

// File: rtl/fsg_phase_step.sv
module fsg_phase_step #(
    parameter int N_W = 24,
    parameter int M_W = 8,
    localparam int S_W = N_W + 1
) (
    input  logic [N_W-1:0] acc,
    input  logic [N_W-1:0] num,
    input  logic [M_W:0]   den,
    output logic           fire,
    output logic [N_W-1:0] acc_next
);
    logic [S_W-1:0] sum;
    logic [S_W-1:0] num_x;
    logic [S_W-1:0] den_x;
    logic [S_W-1:0] diff;

    always_comb begin
        num_x    = {1'b0, num};
        den_x    = {{(S_W-M_W-1){1'b0}}, den};
        sum      = {1'b0, acc} + den_x;
        diff     = sum - num_x;
        fire     = 1'b0;
        acc_next = '0;
        if (num != '0) begin
            if (num_x <= den_x) begin
                fire = 1'b1;
            end else if (sum >= num_x) begin
                fire     = 1'b1;
                acc_next = diff[N_W-1:0];
            end else begin
                acc_next = sum[N_W-1:0];
            end
        end
    end
endmodule

// File: rtl/frac_strobe_gen.sv
module frac_strobe_gen #(
    parameter int N_W = fsg_pkg::FSG_N_W,
    parameter int M_W = fsg_pkg::FSG_M_W,
    localparam int CFG_W = N_W + M_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             strobe_o
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [N_W-1:0]   acc;
        logic             strobe;
    } state_t;

    state_t state_d, state_q;

    logic [N_W-1:0] num;
    logic [M_W:0]   den;
    logic           step_fire;
    logic [N_W-1:0] step_acc;

    fsg_field_split #(.N_W(N_W), .M_W(M_W)) u_split (
        .cfg (state_q.cfg),
        .num (num),
        .den (den)
    );

    fsg_phase_step #(.N_W(N_W), .M_W(M_W)) u_step (
        .acc      (state_q.acc),
        .num      (num),
        .den      (den),
        .fire     (step_fire),
        .acc_next (step_acc)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cfg = cfg_i;
        if (!en_i || (cfg_i != state_q.cfg)) begin
            state_d.acc    = '0;
            state_d.strobe = 1'b0;
        end else begin
            state_d.acc    = step_acc;
            state_d.strobe = step_fire;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign strobe_o = state_q.strobe;
endmodule

// File: rtl/frac_strobe_gen_chk.sv
module frac_strobe_gen_chk #(
    parameter int N_W = 24,
    parameter int M_W = 8,
    localparam int CFG_W = N_W + M_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic [CFG_W-1:0] cfg_i,
    input logic             strobe_o,
    input logic [CFG_W-1:0] cfg_q,
    input logic [N_W-1:0]   acc_q
);
    logic [N_W:0] num_in;
    logic [N_W:0] den_in;
    assign num_in = {1'b0, cfg_i[CFG_W-1:M_W]};
    assign den_in = {{(N_W-M_W){1'b0}}, cfg_i[M_W-1:0]} + 1'b1;

    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!strobe_o && acc_q == '0);
        end
    end

    assert_phase_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == '0) || (acc_q < cfg_q[CFG_W-1:M_W]));

    assert_zero_n_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cfg_i == cfg_q && num_in == '0) |=> !strobe_o);

    assert_fast_every_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cfg_i == cfg_q && num_in != '0 && num_in <= den_in) |=> strobe_o);

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!strobe_o && acc_q == '0));

    assert_new_cfg_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i != cfg_q) |=> (!strobe_o && acc_q == '0 && cfg_q == $past(cfg_i)));
endmodule

bind frac_strobe_gen frac_strobe_gen_chk #(.N_W(N_W), .M_W(M_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .cfg_i    (cfg_i),
    .strobe_o (strobe_o),
    .cfg_q    (state_q.cfg),
    .acc_q    (state_q.acc)
);

// File: tb/frac_strobe_gen_tb.sv
module frac_strobe_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [31:0] cfg_i = '0;
    logic        strobe_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    frac_strobe_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .cfg_i    (cfg_i),
        .strobe_o (strobe_o)
    );

    always #10 clk = ~clk;

    function automatic bit exp_strobe(longint n, longint d, longint t);
        if (n == 0) return 1'b0;
        if (n <= d) return 1'b1;
        return ((t * d) / n) > (((t - 1) * d) / n);
    endfunction

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: strobe=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Called just after a falling edge: load config with enable low, wait one edge.
    task automatic start(int n, int m);
        cfg_i = {n[23:0], m[7:0]};
        en_i  = 1'b0;
        @(negedge clk);
    endtask

    // Enable and check edges t = 1..cyc against the floor formula.
    task automatic run_seq(int n, int m, int cyc, string tag);
        en_i = 1'b1;
        for (int t = 1; t <= cyc; t++) begin
            @(negedge clk);
            check(tag, strobe_o, exp_strobe(n, m + 1, t));
        end
    endtask

    task automatic window(int n, int m, int k);
        int cnt;
        cnt = 0;
        start(n, m);
        en_i = 1'b1;
        for (int t = 1; t <= k * n; t++) begin
            @(negedge clk);
            cnt += int'(strobe_o);
        end
        checks++;
        if (cnt != k * (m + 1)) begin
            errors++;
            $display("FAIL R4: count=%0d expected %0d (N=%0d M=%0d)", cnt, k * (m + 1), n, m);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", strobe_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", strobe_o, 1'b0);

        // R2/R3/R5/R6 sweep: N in bits 31:8, M in bits 7:0
        for (int n = 0; n <= 40; n++) begin
            for (int m = 0; m < 8; m++) begin
                start(n, m);
                if (n == 0)          run_seq(n, m, 6, "R5");
                else if (n <= m + 1) run_seq(n, m, 2 * n + 3, "R6");
                else                 run_seq(n, m, 2 * n + 3, "R3");
            end
        end
        start(300, 255);
        run_seq(300, 255, 20, "R2");
        start(0, 255);
        run_seq(0, 255, 8, "R5");

        window(1000, 255, 2);
        window(777, 100, 3);
        window(37, 5, 4);

        // R7: disable mid-run just before a strobe is due
        start(10, 2);
        run_seq(10, 2, 3, "R7");
        en_i = 1'b0;
        @(negedge clk);
        check("R7", strobe_o, 1'b0);
        run_seq(10, 2, 12, "R7");

        // R8: new config mid-run suppresses the strobe due at t=4
        start(10, 2);
        run_seq(10, 2, 3, "R8");
        cfg_i = {24'd13, 8'd4};
        @(negedge clk);
        check("R8", strobe_o, 1'b0);
        run_seq(13, 4, 20, "R8");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule